// File: doc/BRIEF.md
# Scaled 48-bit Real-Time Counter

This block keeps a 48-bit time count that advances by one on every pulse of an external 31250 Hz tick enable while counting is enabled. Software reaches it over a simple 32-bit register port with a one-cycle read latency. The count is visible as two words, the low 32 bits and the high 16 bits. Either word can be written on its own to preset the count. Reading the low word captures the high word, so a low read followed by a high read yields one coherent 48-bit value.

A 4-bit scale picks a 32-bit window of the count, starting at bit position `scale`, for alarm comparison. When that window is at or above the compare register, a pending flag is raised and driven out as an interrupt. The flag is recomputed on every cycle, so raising the compare value above the window clears it. A typical sequence is: preset the count, set the scale and enable in the config word, then program the compare value for the wake-up time.

Top module: `rtc_scaled_timer`

## Requirements
- R1: While reset is asserted, `rdata_o` and `irq_o` are 0. Reset clears the count, scale, enable and compare registers, so after reset the count words and the compare register read 0.
- R2: With the enable bit (config bit 12) set, each cycle with `tick_i` high adds one to the 48-bit count. A carry out of bit 31 propagates into bits [47:32].
- R3: With the enable bit clear, the count holds its value whatever `tick_i` does.
- R4: A write to offset 0x08 replaces count bits [31:0] with `wdata_i`. A write to offset 0x0C replaces count bits [47:32] with `wdata_i[15:0]` and ignores the upper half of the data. A count write in the same cycle as a tick wins over the increment.
- R5: A read of offset 0x0C returns, in bits [15:0], the count bits [47:32] captured by the most recent read of offset 0x08. Bits [31:16] of that read are 0.
- R6: Config (offset 0x00) reads back scale in [3:0], enable in bit 12 and the pending flag in bit 28. All other bits read 0. Writes change only scale and enable.
- R7: The compare register at offset 0x20 holds a 32-bit value that reads back as written.
- R8: One cycle after any state change, the pending flag equals (count >> scale)[31:0] >= compare, for every scale 0 to 15. It clears once compare is raised above that window.
- R9: `irq_o` equals the pending flag and rises when counting carries the scaled window up to the compare value.
- R10: A read returns its data on `rdata_o` in the cycle after the request and 0 in cycles without a read. Unmapped offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 31250 Hz count enable pulse, one cycle wide |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Alarm interrupt, equal to the pending flag |

## Verification
The assertions assume that `req_i`, `we_i`, `addr_i` and `wdata_i` are known whenever reset is released, and that only one register is addressed per request. A count write and a tick in the same cycle are allowed and are covered by the priority rule. The stimulus drives every input on the falling clock edge. It issues one access per request and raises ticks only as single-cycle pulses. The same-cycle collision of a write and a tick is created on purpose, once.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int OFF_CFG   = 'h00;
  localparam int OFF_CNTLO = 'h08;
  localparam int OFF_CNTHI = 'h0C;
  localparam int OFF_CMP   = 'h20;
  localparam int EN_BIT    = 12;
  localparam int PEND_BIT  = 28;
endpackage

// File: rtl/rtc_count.sv
module rtc_count #(
  parameter int CNT_W = 48,
  parameter int DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [CNT_W-1:0] count_o
);
  localparam int HW = CNT_W - DW;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      // preset beats increment
      if (wr_lo_i) count_q[DW-1:0]    <= wdata_i;
      if (wr_hi_i) count_q[CNT_W-1:DW] <= wdata_i[HW-1:0];
    end else if (en_i && tick_i) begin
      count_q <= count_q + CNT_W'(1);
    end
  end

  assign count_o = count_q;

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !wr_lo_i && !wr_hi_i) |=> count_o == $past(count_o) + CNT_W'(1));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_lo_i && !wr_hi_i) |=> $stable(count_o));
  p_preset_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> count_o[DW-1:0] == $past(wdata_i));
  p_preset_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> count_o[CNT_W-1:DW] == $past(wdata_i[HW-1:0]));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int CNT_W   = 48,
  parameter int DW      = 32,
  parameter int SCALE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   count_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [DW-1:0]      cmp_i,
  output logic               pending_o
);
  localparam int NSCALE = 2 ** SCALE_W;

  logic [DW-1:0] slices [NSCALE];
  logic [DW-1:0] scaled;
  logic          pending_q;

  for (genvar s = 0; s < NSCALE; s++) begin : g_slice
    assign slices[s] = DW'(count_i >> s);
  end

  assign scaled = slices[scale_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_q <= 1'b0;
    else         pending_q <= (scaled >= cmp_i);
  end

  assign pending_o = pending_q;

  p_zero_cmp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i == '0) |=> pending_o);
  p_max_cmp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i == '1 && count_i[DW-1:0] != '1 && scale_i == '0) |=> !pending_o);
endmodule

// File: rtl/rtc_readback.sv
module rtc_readback #(
  parameter int CNT_W = 48,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    cfg_word_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [DW-1:0]    cmp_i,
  output logic [DW-1:0]    rdata_o
);
  import rtc_pkg::*;
  localparam int HW = CNT_W - DW;

  logic [HW-1:0] hi_shadow_q;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rmux;
  logic          mapped;

  always_comb begin
    rmux   = '0;
    mapped = 1'b1;
    case (addr_i)
      AW'(OFF_CFG):   rmux = cfg_word_i;
      AW'(OFF_CNTLO): rmux = count_i[DW-1:0];
      AW'(OFF_CNTHI): rmux = DW'(hi_shadow_q);
      AW'(OFF_CMP):   rmux = cmp_i;
      default:        mapped = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q     <= '0;
      hi_shadow_q <= '0;
    end else begin
      rdata_q <= rd_i ? rmux : '0;
      if (rd_i && addr_i == AW'(OFF_CNTLO)) hi_shadow_q <= count_i[CNT_W-1:DW];
    end
  end

  assign rdata_o = rdata_q;

  p_hi_upper_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == AW'(OFF_CNTHI)) |=> rdata_o[DW-1:HW] == '0);
  p_lo_value_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == AW'(OFF_CNTLO)) |=> rdata_o == $past(count_i[DW-1:0]));
  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !mapped) |=> rdata_o == '0);
  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == '0);
endmodule

// File: rtl/rtc_scaled_timer.sv
module rtc_scaled_timer #(
  parameter int CNT_W   = 48,
  parameter int DW      = 32,
  parameter int AW      = 8,
  parameter int SCALE_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  import rtc_pkg::*;

  logic               wr, rd;
  logic               wr_cfg, wr_lo, wr_hi, wr_cmp;
  logic [SCALE_W-1:0] scale_q;
  logic               en_q;
  logic [DW-1:0]      cmp_q;
  logic [CNT_W-1:0]   count;
  logic               pending;
  logic [DW-1:0]      cfg_word;

  assign wr     = req_i & we_i;
  assign rd     = req_i & ~we_i;
  assign wr_cfg = wr && addr_i == AW'(OFF_CFG);
  assign wr_lo  = wr && addr_i == AW'(OFF_CNTLO);
  assign wr_hi  = wr && addr_i == AW'(OFF_CNTHI);
  assign wr_cmp = wr && addr_i == AW'(OFF_CMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scale_q <= '0;
      en_q    <= 1'b0;
      cmp_q   <= '0;
    end else begin
      if (wr_cfg) begin
        scale_q <= wdata_i[SCALE_W-1:0];
        en_q    <= wdata_i[EN_BIT];
      end
      if (wr_cmp) cmp_q <= wdata_i;
    end
  end

  always_comb begin
    cfg_word                = '0;
    cfg_word[SCALE_W-1:0]   = scale_q;
    cfg_word[EN_BIT]        = en_q;
    cfg_word[PEND_BIT]      = pending;
  end

  rtc_count #(.CNT_W(CNT_W), .DW(DW)) u_count (
    .clk_i, .rst_ni,
    .en_i(en_q), .tick_i,
    .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wdata_i, .count_o(count)
  );

  rtc_alarm #(.CNT_W(CNT_W), .DW(DW), .SCALE_W(SCALE_W)) u_alarm (
    .clk_i, .rst_ni,
    .count_i(count), .scale_i(scale_q), .cmp_i(cmp_q),
    .pending_o(pending)
  );

  rtc_readback #(.CNT_W(CNT_W), .DW(DW), .AW(AW)) u_rb (
    .clk_i, .rst_ni,
    .rd_i(rd), .addr_i,
    .cfg_word_i(cfg_word), .count_i(count), .cmp_i(cmp_q),
    .rdata_o
  );

  assign irq_o = pending;

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (rdata_o == '0 && !irq_o));
  p_cmp_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmp |=> cmp_q == $past(wdata_i));
  p_cfg_foreign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cfg |=> ($stable(scale_q) && $stable(en_q)));
endmodule

// File: tb/rtc_scaled_timer_test.sv
module rtc_scaled_timer_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic        rd_seen = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  rtc_scaled_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic with_tick = 1'b0);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; tick = with_tick;
    @(negedge clk);
    req = 1'b0; we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    check(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  // monitor: read issued at previous edge, data valid now
  always @(posedge clk) rd_seen <= req & ~we;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected read data", 32'h1, 32'h0);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog expired", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", rdata, 32'h0);
    check("R1 irq in reset", {31'b0, irq}, 32'h0);
    rst_ni = 1'b1;
    rd(8'h08, 32'h0, "R1 count low after reset");
    rd(8'h0C, 32'h0, "R1 count high after reset");
    rd(8'h20, 32'h0, "R1 R7 compare after reset");
    // compare 0 -> pending, config shows bit 28 only
    rd(8'h00, 32'h1000_0000, "R6 R8 config pending at cmp 0");
    check("R9 irq with cmp 0", {31'b0, irq}, 32'h1);

    wr(8'h20, 32'd100);
    chk_irq(1'b0, "R8 clears when cmp raised");
    rd(8'h20, 32'd100, "R7 compare readback");

    // enable, junk bits ignored
    wr(8'h00, 32'hFFFF_FFF0);
    rd(8'h00, 32'h0000_1000, "R6 config readback masks");
    pulse(5);
    rd(8'h08, 32'd5, "R2 five ticks");

    wr(8'h00, 32'h0);
    pulse(3);
    rd(8'h08, 32'd5, "R3 hold while disabled");

    // preset with carry into high
    wr(8'h08, 32'hFFFF_FFFE);
    wr(8'h0C, 32'h1234_ABCD);
    wr(8'h00, 32'h0000_1000);
    pulse(3);
    wr(8'h00, 32'h0);
    rd(8'h08, 32'h0000_0001, "R4 R2 low after carry");
    rd(8'h0C, 32'h0000_ABCE, "R4 R5 high after carry");

    // shadow coherency
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h0000_0001);
    wr(8'h00, 32'h0000_1000);
    rd(8'h08, 32'hFFFF_FFFF, "R5 low before carry");
    pulse(1);
    rd(8'h0C, 32'h0000_0001, "R5 high from shadow");
    rd(8'h08, 32'h0000_0000, "R5 low after carry");
    rd(8'h0C, 32'h0000_0002, "R5 high after new low read");
    wr(8'h00, 32'h0);

    // scale windows, count = 0x2_0000_0000
    wr(8'h00, 32'h4);
    wr(8'h20, 32'h2000_0000);
    chk_irq(1'b1, "R8 scale 4 equal");
    wr(8'h20, 32'h2000_0001);
    chk_irq(1'b0, "R8 scale 4 above");
    wr(8'h00, 32'hF);
    wr(8'h20, 32'h0004_0000);
    chk_irq(1'b1, "R8 scale 15 equal");
    wr(8'h20, 32'h0004_0001);
    chk_irq(1'b0, "R8 scale 15 above");

    // write beats tick
    wr(8'h00, 32'h0000_1000);
    wr(8'h0C, 32'h0);
    wr(8'h08, 32'd10, 1'b1);
    rd(8'h08, 32'd10, "R4 write wins over tick");

    // counting up to compare raises irq
    wr(8'h20, 32'd12);
    chk_irq(1'b0, "R9 below compare");
    pulse(1);
    chk_irq(1'b0, "R9 one below compare");
    pulse(1);
    chk_irq(1'b1, "R9 count reaches compare");
    wr(8'h00, 32'h0);

    // unmapped offsets
    wr(8'h04, 32'hDEAD_BEEF);
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h04, 32'h0, "R10 unmapped 0x04 reads zero");
    rd(8'h10, 32'h0, "R10 unmapped 0x10 reads zero");
    rd(8'h20, 32'd12, "R10 compare unchanged by unmapped write");
    rd(8'h08, 32'd12, "R10 count unchanged by unmapped write");

    repeat (3) @(negedge clk);
    check("R10 all reads returned", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule